// File: doc/BRIEF.md
# Single-Bank GPIO Controller with Per-Pin Interrupt Detection

This block controls one bank of 32 general-purpose pins through a small register interface. Software selects, pin by pin, whether the pin drives a value out or is sampled as an input, and reads the synchronized input value. Software can also set per-pin pull-resistor controls, which are passed directly to the pad.

Each pin has its own interrupt detector. It can sense a level or an edge. Edge sensing can take the rising edge, the falling edge or both edges. Detected events are latched in a raw status word. A mask word selects which latched bits count. A write-one-to-clear register acknowledges events. The OR of all unmasked latched bits, registered once, forms the single interrupt output.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every register reads zero, pad_oe, pad_out, pull_en, pull_up and irq are all zero, so every pin is an input with its interrupt masked.
- R2: Writing offset 0x04 (output value) and offset 0x08 (output enable, 1 = drive) sets pad_out and pad_oe one clock after the write, and both registers read back what was written.
- R3: Offset 0x00 returns pad_in through a two-flop synchronizer, so a change becomes visible after two clock edges and not after one.
- R4: In edge mode (offset 0x0C bit = 0, offset 0x10 bit = 0) with polarity bit at offset 0x14 = 1, a rising input sets that pin's raw status bit (offset 0x1C) and a falling input does not.
- R5: In edge mode with polarity 0 and dual-edge 0, a falling input sets the raw status bit and a rising input does not.
- R6: With the dual-edge bit (offset 0x10) set in edge mode, both edges set the raw status bit whatever the polarity bit holds.
- R7: In level mode (offset 0x0C bit = 1), the raw bit is set while the synchronized input equals the polarity bit (1 = high active, 0 = low active), it sets again right after a clear while the level persists, and the dual-edge bit has no effect.
- R8: Offset 0x20 reads raw status ANDed with the mask at offset 0x18 (1 = enabled), and irq equals the OR of those bits one clock later.
- R9: Writing 1 to a bit of offset 0x24 clears that raw bit, writing 0 leaves it, the register reads zero, and an event arriving in the same cycle as its clear keeps the bit set.
- R10: Offset 0x38 (pull enable) drives pull_en and offset 0x34 (1 = pull-up, 0 = pull-down) drives pull_up, each readable back.
- R11: Reads of undefined offsets return zero, and writes to offsets 0x00, 0x1C, 0x20 or undefined offsets change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe, sampled on the clock edge |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pad_in | input | NPINS | Raw pin inputs |
| pad_out | output | NPINS | Output values to the pads |
| pad_oe | output | NPINS | Output enables to the pads |
| pull_en | output | NPINS | Pull-resistor enables |
| pull_up | output | NPINS | Pull direction select, 1 = up |
| irq | output | 1 | Registered OR of masked status |

## Verification
The assertions assume pad_in is low while reset is active, so the synchronizer and its previous-value flop start equal and no phantom edge reaches the status word. They also assume the register port gives one write per clock, with address and data held steady across the sampling edge. The stimulus changes pad_in and all register signals only on falling clock edges and keeps the pins low through reset. Collision cases are timed so that a clear and an event share the same rising edge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned REG_AW = 6;
  localparam int unsigned REG_DW = 32;

  typedef enum logic [REG_AW-1:0] {
    OFS_DIN  = 6'h00,
    OFS_DOUT = 6'h04,
    OFS_OE   = 6'h08,
    OFS_LVL  = 6'h0C,
    OFS_BOTH = 6'h10,
    OFS_POL  = 6'h14,
    OFS_MASK = 6'h18,
    OFS_RAW  = 6'h1C,
    OFS_MSK  = 6'h20,
    OFS_CLR  = 6'h24,
    OFS_PSEL = 6'h34,
    OFS_PEN  = 6'h38
  } reg_ofs_e;

  typedef struct packed {
    logic lvl;   // 1 = level sensing
    logic both;  // 1 = either edge (edge mode only)
    logic pol;   // 1 = rising / high
  } trig_cfg_t;

  // One pin's event for this cycle, from its config and input history.
  function automatic logic trig_event(trig_cfg_t c, logic cur, logic prev);
    if (c.lvl)       return cur == c.pol;
    else if (c.both) return cur ^ prev;
    else if (c.pol)  return cur & ~prev;
    else             return ~cur & prev;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] cur,
  output logic [NPINS-1:0] prev
);
  logic [NPINS-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      cur    <= '0;
      prev   <= '0;
    end else begin
      stage1 <= pad_in;
      cur    <= stage1;
      prev   <= cur;
    end
  end
endmodule

// File: rtl/gpio_irq_core.sv
module gpio_irq_core
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] cfg_lvl,
  input  logic [NPINS-1:0] cfg_both,
  input  logic [NPINS-1:0] cfg_pol,
  input  logic [NPINS-1:0] cfg_mask,
  input  logic [NPINS-1:0] cur,
  input  logic [NPINS-1:0] prev,
  input  logic [NPINS-1:0] clr,
  output logic [NPINS-1:0] evt,
  output logic [NPINS-1:0] raw,
  output logic [NPINS-1:0] masked,
  output logic             irq
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    trig_cfg_t cfg;
    assign cfg    = '{lvl: cfg_lvl[i], both: cfg_both[i], pol: cfg_pol[i]};
    assign evt[i] = trig_event(cfg, cur[i], prev[i]);
  end

  assign masked = raw & cfg_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw <= '0;
      irq <= 1'b0;
    end else begin
      raw <= (raw & ~clr) | evt;   // event wins over a same-cycle clear
      irq <= |masked;
    end
  end

  // R4 R5 R6 R7: an event always lands in the raw word
  p_event_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw & $past(evt)) == $past(evt)));
  // R9: a clear without a competing event empties the bit
  p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw & $past(clr & ~evt)) == '0));
  // R4: no raw bit rises without an event
  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw & ~$past(raw) & ~$past(evt)) == '0));
  // R8: interrupt line follows masked status with one register
  p_irq_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|masked)));
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  output logic [REG_DW-1:0] rdata,
  input  logic [NPINS-1:0]  din,
  input  logic [NPINS-1:0]  raw,
  input  logic [NPINS-1:0]  masked,
  output logic [NPINS-1:0]  dout,
  output logic [NPINS-1:0]  oe,
  output logic [NPINS-1:0]  lvl,
  output logic [NPINS-1:0]  both,
  output logic [NPINS-1:0]  pol,
  output logic [NPINS-1:0]  mask,
  output logic [NPINS-1:0]  psel,
  output logic [NPINS-1:0]  pen,
  output logic [NPINS-1:0]  clr
);
  logic [NPINS-1:0] wbits;
  assign wbits = NPINS'(wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0; oe <= '0; lvl <= '0; both <= '0;
      pol  <= '0; mask <= '0; psel <= '0; pen <= '0;
    end else if (we) begin
      case (addr)
        OFS_DOUT: dout <= wbits;
        OFS_OE:   oe   <= wbits;
        OFS_LVL:  lvl  <= wbits;
        OFS_BOTH: both <= wbits;
        OFS_POL:  pol  <= wbits;
        OFS_MASK: mask <= wbits;
        OFS_PSEL: psel <= wbits;
        OFS_PEN:  pen  <= wbits;
        default: ;
      endcase
    end
  end

  assign clr = (we && addr == OFS_CLR) ? wbits : '0;

  always_comb begin
    case (addr)
      OFS_DIN:  rdata = REG_DW'(din);
      OFS_DOUT: rdata = REG_DW'(dout);
      OFS_OE:   rdata = REG_DW'(oe);
      OFS_LVL:  rdata = REG_DW'(lvl);
      OFS_BOTH: rdata = REG_DW'(both);
      OFS_POL:  rdata = REG_DW'(pol);
      OFS_MASK: rdata = REG_DW'(mask);
      OFS_RAW:  rdata = REG_DW'(raw);
      OFS_MSK:  rdata = REG_DW'(masked);
      OFS_PSEL: rdata = REG_DW'(psel);
      OFS_PEN:  rdata = REG_DW'(pen);
      default:  rdata = '0;
    endcase
  end

  // R11: writes to read-only offsets leave the writable state alone
  p_ro_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (addr == OFS_DIN || addr == OFS_RAW || addr == OFS_MSK))
      |=> ($stable(dout) && $stable(oe) && $stable(mask) && $stable(pen)));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pull_en,
  output logic [NPINS-1:0]  pull_up,
  output logic              irq
);
  logic [NPINS-1:0] cur, prev, evt, raw, masked, clr;
  logic [NPINS-1:0] lvl, both, pol, mask;

  gpio_in_sync #(.NPINS(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .cur(cur), .prev(prev)
  );

  gpio_regfile #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .din(cur), .raw(raw),
    .masked(masked), .dout(pad_out), .oe(pad_oe), .lvl(lvl),
    .both(both), .pol(pol), .mask(mask), .psel(pull_up), .pen(pull_en),
    .clr(clr)
  );

  gpio_irq_core #(.NPINS(NPINS)) u_irq (
    .clk(clk), .rst_n(rst_n), .cfg_lvl(lvl), .cfg_both(both),
    .cfg_pol(pol), .cfg_mask(mask), .cur(cur), .prev(prev), .clr(clr),
    .evt(evt), .raw(raw), .masked(masked), .irq(irq)
  );
endmodule

// File: tb/gpio_bank_ctrl_bench.sv
module gpio_bank_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] A_DIN = 6'h00, A_DOUT = 6'h04, A_OE = 6'h08,
    A_LVL = 6'h0C, A_BOTH = 6'h10, A_POL = 6'h14, A_MASK = 6'h18,
    A_RAW = 6'h1C, A_MSK = 6'h20, A_CLR = 6'h24, A_PSEL = 6'h34,
    A_PEN = 6'h38;

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, pad_in = '0;
  logic [31:0] pad_out, pad_oe, pull_en, pull_up;
  logic irq;
  int checks = 0, errors = 0;
  logic [31:0] d;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank_ctrl u_gpio_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pull_en(pull_en),
    .pull_up(pull_up), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] v);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setpin(input int p, input logic v);
    @(negedge clk); pad_in[p] = v;
  endtask

  task automatic mode(input logic [31:0] l, input logic [31:0] b, input logic [31:0] p);
    wr(A_LVL, l); wr(A_BOTH, b); wr(A_POL, p); idle(3); wr(A_CLR, '1);
  endtask

  task automatic t_reset;
    chk("R1 pad_oe", pad_oe, 0); chk("R1 pad_out", pad_out, 0);
    chk("R1 irq", {31'b0, irq}, 0); chk("R1 pulls", pull_en | pull_up, 0);
    foreach (d[i]) begin end
    for (int a = 0; a < 64; a += 4) begin rd(a[5:0], d); chk("R1 reg", d, 0); end
  endtask

  task automatic t_outputs;
    wr(A_DOUT, 32'hA5C3_0F81); wr(A_OE, 32'h8000_00FF);
    chk("R2 pad_out", pad_out, 32'hA5C3_0F81); chk("R2 pad_oe", pad_oe, 32'h8000_00FF);
    rd(A_DOUT, d); chk("R2 readback", d, 32'hA5C3_0F81);
    rd(A_OE, d);   chk("R2 oe readback", d, 32'h8000_00FF);
  endtask

  task automatic t_input;
    @(negedge clk); pad_in = 32'h0000_1200;
    @(negedge clk); rd(A_DIN, d); chk("R3 one edge", d, 0);
    @(negedge clk); rd(A_DIN, d); chk("R3 two edges", d, 32'h0000_1200);
    pad_in = '0; idle(3);
  endtask

  task automatic t_rising;
    mode(0, 0, 32'h20);
    setpin(5, 1); idle(3); rd(A_RAW, d); chk("R4 rise sets", d, 32'h20);
    wr(A_CLR, 32'h20); setpin(5, 0); idle(3); rd(A_RAW, d); chk("R4 fall ignored", d, 0);
  endtask

  task automatic t_falling;
    mode(0, 0, 0);
    setpin(9, 1); idle(3); rd(A_RAW, d); chk("R5 rise ignored", d, 0);
    setpin(9, 0); idle(3); rd(A_RAW, d); chk("R5 fall sets", d, 32'h200);
  endtask

  task automatic t_dual;
    mode(0, 32'h1, 32'h1);
    setpin(0, 1); idle(3); rd(A_RAW, d); chk("R6 rise", d, 32'h1);
    wr(A_CLR, 32'h1);
    setpin(0, 0); idle(3); rd(A_RAW, d); chk("R6 fall", d, 32'h1);
    wr(A_CLR, 32'h1);
  endtask

  task automatic t_level;
    mode(32'h8000_0000, 32'h8000_0000, 32'h8000_0000);
    rd(A_RAW, d); chk("R7 inactive", d, 0);
    setpin(31, 1); idle(3); rd(A_RAW, d); chk("R7 high sets", d, 32'h8000_0000);
    wr(A_CLR, 32'h8000_0000); rd(A_RAW, d); chk("R7 resets after clear", d, 32'h8000_0000);
    // drop the level, clear on the edge where only a dual-edge event could exist
    @(negedge clk); pad_in[31] = 1'b0;
    @(negedge clk);
    wr(A_CLR, 32'h8000_0000); rd(A_RAW, d); chk("R7 dual ignored", d, 0);
    idle(2); rd(A_RAW, d); chk("R7 stays clear", d, 0);
  endtask

  task automatic t_mask_irq;
    mode(32'h8000_0000, 0, 32'h8000_0000); wr(A_MASK, 0);
    setpin(31, 1); idle(4);
    rd(A_MSK, d); chk("R8 masked off", d, 0); chk("R8 irq off", {31'b0, irq}, 0);
    wr(A_MASK, 32'h8000_0001);
    rd(A_MSK, d); chk("R8 masked on", d, 32'h8000_0000);
    chk("R8 irq lag", {31'b0, irq}, 0);
    @(negedge clk); chk("R8 irq set", {31'b0, irq}, 1);
    wr(A_MASK, 0); @(negedge clk); chk("R8 irq drop", {31'b0, irq}, 0);
    setpin(31, 0); idle(3); wr(A_CLR, '1);
  endtask

  task automatic t_clear;
    mode(0, 32'h0000_4010, 0);
    setpin(4, 1); setpin(14, 1); idle(3); rd(A_RAW, d); chk("R9 both set", d, 32'h4010);
    wr(A_CLR, 32'h0000_0010); rd(A_RAW, d); chk("R9 one cleared", d, 32'h4000);
    wr(A_CLR, 0); rd(A_RAW, d); chk("R9 zero write no effect", d, 32'h4000);
    rd(A_CLR, d); chk("R9 reads zero", d, 0);
    // new edge on pin 14 meets its clear on the same rising edge
    @(negedge clk); pad_in[14] = 1'b0;
    @(negedge clk);
    wr(A_CLR, 32'h4000); rd(A_RAW, d); chk("R9 event wins", d, 32'h4000);
    wr(A_CLR, 32'h4000); rd(A_RAW, d); chk("R9 later clear", d, 0);
    setpin(4, 0); idle(3); wr(A_CLR, '1);
  endtask

  task automatic t_pulls;
    wr(A_PEN, 32'h0F00_00F0); wr(A_PSEL, 32'h0300_0030);
    chk("R10 pull_en", pull_en, 32'h0F00_00F0); chk("R10 pull_up", pull_up, 32'h0300_0030);
    rd(A_PEN, d); chk("R10 en readback", d, 32'h0F00_00F0);
    rd(A_PSEL, d); chk("R10 sel readback", d, 32'h0300_0030);
  endtask

  task automatic t_undef;
    wr(6'h28, '1); wr(6'h3C, '1); wr(A_DIN, '1); wr(A_RAW, '1); wr(A_MSK, '1);
    rd(6'h28, d); chk("R11 undef read", d, 0);
    rd(6'h2C, d); chk("R11 undef read2", d, 0);
    rd(A_RAW, d); chk("R11 raw untouched", d, 0);
    rd(A_DIN, d); chk("R11 din untouched", d, 0);
    chk("R11 oe untouched", pad_oe, 32'h8000_00FF);
    chk("R11 pen untouched", pull_en, 32'h0F00_00F0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1'b1; idle(1);
    t_reset(); t_outputs(); t_input(); t_rising(); t_falling(); t_dual();
    t_level(); t_mask_irq(); t_clear(); t_pulls(); t_undef();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule